// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns frames arriving on a single idle-high serial line into characters for a processor, and keeps a small status byte describing the health of the line. It runs on the system clock and advances its bit timing only on a one-cycle enable pulse that occurs sixteen times per bit period. That pulse is produced outside the block. The frame shape is set by static configuration inputs: character length, parity enable and parity mode, and one or two stop bits.

A received character is placed in a buffer register, and the ready flag is raised. The processor takes the character with a buffer read strobe and reads the status byte with a status read strobe. The status byte carries four error indications: overrun, parity, framing and line break. All four are cleared by a status read. An active-low ready pin mirrors the ready flag, so polling the status byte is not needed to see that a character has arrived.

Top module: `uart_rx_line`

## Requirements
- R1: After reset the status byte reads 0x00, the ready pin is high and the buffer holds 0x00.
- R2: The character length is 5, 6, 7 or 8 bits for `len_sel` 0, 1, 2 or 3. Bits arrive least significant first after a low start bit. The buffer holds the character in its low bits, with all unused upper bits at zero.
- R3: A low level on the line is taken as a start bit only when the falling-edge sample and the next three samples are all low. A shorter low pulse produces no character and leaves the status byte unchanged.
- R4: Parity is checked only when `par_on` is 1. `par_sel` selects the expected parity bit: 0 gives even (the bit equals the XOR of the data bits), 1 gives odd, 2 gives a constant one and 3 gives a constant zero. A mismatch sets the parity flag. No parity flag is ever raised while `par_on` is 0.
- R5: The framing flag is set when the first stop bit is sampled low at its centre. When two stop bits are configured, the second one is never checked.
- R6: The break flag is set as soon as the line has been low for more samples in a row than a full frame spans (start, data, parity and stop bits, sixteen samples each). The framing flag is set together with it. After a status read clears the flag, it is not raised again until the line has gone high and a new low period begins.
- R7: Every completed frame, including one with errors, loads its data bits into the buffer and sets the ready flag. `ready_n` is the inverse of the ready flag.
- R8: A load that occurs while the ready flag is set and no buffer read is happening sets the overrun flag. The older character is replaced, and the ready flag stays set.
- R9: Status byte layout: bit 0 is ready, bit 1 is break, bit 2 is framing, bit 3 is parity, bit 4 is overrun, and bits 7 to 5 are zero. A status read clears bits 4 to 1 and leaves bit 0 unchanged. An error raised in the same cycle as the read takes precedence over the clear.
- R10: A buffer read clears the ready flag. When a read and a load fall in the same cycle, the load wins and the ready flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable, sixteen per bit period |
| rx_line | input | 1 | Serial input, idle high |
| len_sel | input | 2 | Character length select (5 + value bits) |
| par_on | input | 1 | Parity bit present and checked |
| par_sel | input | 2 | Parity mode: even, odd, constant one, constant zero |
| two_stop | input | 1 | Two stop bits per frame |
| buf_rd | input | 1 | Buffer read strobe |
| stat_rd | input | 1 | Status byte read strobe |
| buf_data | output | 8 | Receive buffer contents |
| stat | output | 8 | Line status byte |
| ready_n | output | 1 | Active-low character-ready pin |

## Verification
The bench builds the block with its default sixteen samples per bit and a four-sample start check. It supplies one tick every four clock cycles, so a bit lasts 64 cycles and a complete 8-bit frame with parity and two stop bits stays short. At that rate the bench can drive every character length, every parity mode, both stop-bit settings and a break held well past a full frame within a few tens of thousands of cycles. The parameter for the start check also fixes how long a glitch must last before it counts as a start bit; the bench's short low pulse exercises exactly that margin.

// File: rtl/uart_rx_line.sv
module uart_rx_line #(
  parameter int TPB          = 16,
  parameter int START_CHECKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [1:0] len_sel,
  input  logic       par_on,
  input  logic [1:0] par_sel,
  input  logic       two_stop,
  input  logic       buf_rd,
  input  logic       stat_rd,
  output logic [7:0] buf_data,
  output logic [7:0] stat,
  output logic       ready_n
);

  localparam int TW    = $clog2(TPB);
  localparam int MAXB  = 12;
  localparam int BRKW  = $clog2(TPB * MAXB + 2);
  localparam logic [TW-1:0] MID  = TW'(TPB / 2);
  localparam logic [TW-1:0] LAST = TW'(TPB - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2} st_t;

  logic          rx_m, rx_s;
  st_t           state;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    shf;
  logic          pbit, armed;
  logic [BRKW-1:0] lowcnt;
  logic          rdy, ovr_f, pe_f, fe_f, brk_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_line;
      rx_s <= rx_m;
    end

  wire [2:0]    last_bit = 3'(4 + len_sel);
  wire          at_mid   = tick16 && tcnt == MID;
  wire          at_end   = tick16 && tcnt == LAST;
  wire [TW-1:0] tnext    = (tcnt == LAST) ? '0 : tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shf   <= '0;
      pbit  <= 1'b0;
      armed <= 1'b0;
    end else if (tick16) begin
      case (state)
        S_IDLE:
          if (rx_s) armed <= 1'b1;
          else if (armed) begin
            state <= S_START;
            tcnt  <= TW'(1);
            armed <= 1'b0;
            shf   <= '0;
          end
        S_START:
          if (tcnt < TW'(START_CHECKS) && rx_s) begin
            state <= S_IDLE;
            armed <= 1'b1;
          end else begin
            tcnt <= tnext;
            if (tcnt == LAST) begin
              state <= S_DATA;
              bidx  <= '0;
            end
          end
        S_DATA: begin
          tcnt <= tnext;
          if (tcnt == MID) shf[bidx] <= rx_s;
          if (tcnt == LAST) begin
            if (bidx == last_bit) state <= par_on ? S_PAR : S_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        S_PAR: begin
          tcnt <= tnext;
          if (tcnt == MID) pbit <= rx_s;
          if (tcnt == LAST) state <= S_STOP;
        end
        S_STOP: begin
          tcnt <= tnext;
          if (tcnt == MID && !two_stop) state <= S_IDLE;
          else if (tcnt == LAST) state <= S_STOP2;
        end
        S_STOP2: begin
          tcnt <= tnext;
          if (tcnt == LAST) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end

  logic exp_par;
  always_comb
    case (par_sel)
      2'd0:    exp_par = ^shf;
      2'd1:    exp_par = ~^shf;
      2'd2:    exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase

  wire load_now = state == S_STOP && at_mid;
  wire pe_now   = par_on && (pbit != exp_par);
  wire fe_now   = !rx_s;

  wire [BRKW-1:0] frame_bits = BRKW'(2 + 5 + len_sel) + BRKW'(par_on) + BRKW'(two_stop);
  wire [BRKW-1:0] brk_lim    = BRKW'(frame_bits * BRKW'(TPB)) + 1'b1;
  wire            brk_hit    = tick16 && !rx_s && lowcnt == brk_lim - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lowcnt <= '0;
    else if (tick16) begin
      if (rx_s) lowcnt <= '0;
      else if (lowcnt != brk_lim) lowcnt <= lowcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy <= 1'b0; ovr_f <= 1'b0; pe_f <= 1'b0; fe_f <= 1'b0; brk_f <= 1'b0;
      buf_data <= '0;
    end else begin
      if (load_now) buf_data <= shf;
      if (load_now) rdy <= 1'b1;
      else if (buf_rd) rdy <= 1'b0;
      if (load_now && rdy && !buf_rd) ovr_f <= 1'b1;
      else if (stat_rd) ovr_f <= 1'b0;
      if (load_now && pe_now) pe_f <= 1'b1;
      else if (stat_rd) pe_f <= 1'b0;
      if ((load_now && fe_now) || brk_hit) fe_f <= 1'b1;
      else if (stat_rd) fe_f <= 1'b0;
      if (brk_hit) brk_f <= 1'b1;
      else if (stat_rd) brk_f <= 1'b0;
    end

  assign stat    = {3'b000, ovr_f, pe_f, fe_f, brk_f, rdy};
  assign ready_n = !rdy;

  p_brk_fe_r6: assert property (@(posedge clk) disable iff (!rst_n) brk_f |-> fe_f);
  p_pe_en_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(pe_f) |-> $past(par_on));
  p_ovr_src_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_f) |-> $past(rdy));
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n) load_now |=> !ready_n);
  p_rd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n) buf_rd && !load_now |=> ready_n);
  p_stat_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !load_now && !brk_hit |=> stat[4:1] == 4'b0000);

endmodule

// File: tb/uart_rx_line_tb_top.sv
module uart_rx_line_tb_top;
  localparam int DIV = 4;
  localparam int BITC = 16 * DIV;

  logic clk = 0, rst_n = 0, tick16 = 0, rx_line = 1;
  logic [1:0] len_sel = 3, par_sel = 0;
  logic par_on = 0, two_stop = 0, buf_rd = 0, stat_rd = 0;
  logic [7:0] buf_data, stat;
  logic ready_n;
  int checks = 0, fails = 0, tdiv = 0;
  bit mon_en = 0;

  typedef struct { logic [7:0] d; logic pe; logic fe; } exp_t;
  exp_t q[$];

  uart_rx_line dut_i (.clk, .rst_n, .tick16, .rx_line, .len_sel, .par_on, .par_sel,
    .two_stop, .buf_rd, .stat_rd, .buf_data, .stat, .ready_n);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= (tdiv == DIV - 1) ? 0 : tdiv + 1;
    tick16 <= (tdiv == DIV - 1);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit pen, input logic [1:0] pm,
                      input bit pflip, input bit stop_bad, input bit two, input bit s2_low,
                      input bit push);
    logic [7:0] dm;
    logic pb;
    exp_t e;
    dm = d & 8'((1 << n) - 1);
    len_sel = 2'(n - 5); par_on = pen; par_sel = pm; two_stop = two;
    pb = (pm == 0) ? ^dm : (pm == 1) ? ~^dm : (pm == 2);
    pb ^= pflip;
    e.d = dm; e.pe = pen & pflip; e.fe = stop_bad;
    if (push) q.push_back(e);
    hold(0, BITC);
    for (int i = 0; i < n; i++) hold(dm[i], BITC);
    if (pen) hold(pb, BITC);
    hold(!stop_bad, BITC);
    if (two) hold(!s2_low, BITC);
    hold(1, BITC);
  endtask

  task automatic pulse_stat();
    stat_rd = 1; @(negedge clk); stat_rd = 0; @(negedge clk);
  endtask

  task automatic pulse_buf();
    buf_rd = 1; @(negedge clk); buf_rd = 0; @(negedge clk);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (mon_en && ready_n == 0) begin
      if (q.size() == 0) chk("R7 unexpected char", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R2 data", buf_data, e.d);
        chk("R4 parity flag", stat[3], e.pe);
        chk("R5 framing flag", stat[2], e.fe);
        chk("R7 ready bit", stat[0], 1);
        buf_rd = 1; stat_rd = 1;
        @(negedge clk);
        buf_rd = 0; stat_rd = 0;
        chk("R9 flags cleared", stat[4:1], 0);
        chk("R10 ready cleared", ready_n, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", stat, 0);
    chk("R1 ready_n", ready_n, 1);
    chk("R1 buffer", buf_data, 0);
    rst_n = 1;
    hold(1, 2 * BITC);
    mon_en = 1;
    // R2 eight bits, several patterns
    send(8'hA5, 8, 0, 0, 0, 0, 0, 0, 1);
    send(8'h3C, 8, 0, 0, 0, 0, 0, 0, 1);
    send(8'hFF, 8, 0, 0, 0, 0, 0, 0, 1);
    send(8'h00, 8, 0, 0, 0, 0, 0, 0, 1);
    // R2 short characters
    send(8'hF3, 5, 0, 0, 0, 0, 0, 0, 1);
    send(8'hEA, 6, 0, 0, 0, 0, 0, 0, 1);
    send(8'hD5, 7, 0, 0, 0, 0, 1, 0, 1);
    // R4 every parity mode, good and bad
    for (int m = 0; m < 4; m++) begin
      send(8'h5B, 8, 1, 2'(m), 0, 0, 0, 0, 1);
      send(8'h5B, 8, 1, 2'(m), 1, 0, 0, 0, 1);
      send(8'h16, 7, 1, 2'(m), 1, 0, 1, 0, 1);
    end
    // R5 bad first stop; second stop low ignored
    send(8'h81, 8, 0, 0, 0, 1, 0, 0, 1);
    send(8'h42, 8, 1, 0, 0, 0, 1, 1, 1);
    send(8'h24, 6, 0, 0, 0, 1, 1, 0, 1);
    wait (q.size() == 0);
    hold(1, BITC);
    mon_en = 0;
    // R3 false start
    hold(0, 2 * DIV);
    hold(1, 12 * BITC);
    chk("R3 no char after glitch", ready_n, 1);
    chk("R3 status unchanged", stat, 0);
    // R8 overrun
    send(8'h11, 8, 0, 0, 0, 0, 0, 0, 0);
    send(8'h22, 8, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 overrun flag", stat[4], 1);
    chk("R8 newest kept", buf_data, 8'h22);
    chk("R8 ready stays", ready_n, 0);
    pulse_stat();
    chk("R9 overrun cleared", stat[4], 0);
    chk("R9 ready kept", stat[0], 1);
    pulse_buf();
    chk("R10 buffer read clears", ready_n, 1);
    // R6 break, 8N1 frame = 10 bits
    len_sel = 3; par_on = 0; two_stop = 0;
    hold(0, 157 * DIV);
    chk("R6 not yet break", stat[1], 0);
    chk("R5 break frame framing", stat[2], 1);
    chk("R7 break frame loaded", buf_data, 0);
    hold(0, 11 * DIV);
    chk("R6 break set", stat[1], 1);
    chk("R6 framing with break", stat[2], 1);
    pulse_stat();
    chk("R6 break cleared", stat[1], 0);
    hold(0, 12 * BITC);
    chk("R6 no second break", stat[1], 0);
    hold(1, 3 * BITC);
    chk("R6 no frame after break", stat[1], 0);
    pulse_buf();
    chk("R10 ready cleared", ready_n, 1);
    mon_en = 1;
    send(8'h9C, 8, 0, 0, 0, 0, 0, 0, 1);
    wait (q.size() == 0);
    hold(1, BITC);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule